// File: doc/BRIEF.md
# Converter Serial Control Port

This block is the slave side of the three-wire serial control port on an integrating data-acquisition converter. A host uses one direction pin to choose between two transfers. With the pin low it shifts in an 8-bit timing word that sets how long the auto-zero and integrate phases last. With the pin high it shifts out a status-and-result frame.

The frame carries the end-of-conversion flag, the overrange flag, the sign and a 17-bit magnitude, 20 bits in all. The host clock and direction pin are asynchronous to the block. They are sampled by a system clock at least four times faster, through two-flop synchronisers with edge detection. All data movement is keyed to the detected edges.

The timing word is committed to the conversion sequencer on the rising edge of the direction pin, and a one-cycle start pulse goes out at the same moment. A write is honoured only if it was opened while end-of-conversion was low, which is the auto-zero phase. The sequencer is expected to stay idle until the first commit. When no clock edges have yet arrived in read mode, the data output follows end-of-conversion, so the host can poll status on that one pin.

Top module: `conv_serial_port`

## Requirements
- R1: In write mode (`rw_i` low), `din_i` is sampled on each rising edge of `dclk_i`. The first bit sent becomes the most significant bit of the timing word. A change of `din_i` while `dclk_i` is high has no effect.
- R2: A write is accepted only if `eoc_i` is low when the fall of `rw_i` is detected. If it is not, `time_base_o` stays unchanged and no start pulse is issued.
- R3: When `rw_i` rises after an accepted write, the shifted byte is copied to `time_base_o` and `conv_start_o` is high for exactly one system clock.
- R4: If fewer than 8 bits were shifted, those bits land in the low positions of the timing word and the upper bits are zero. If more than 8 bits were shifted, only the last 8 are kept.
- R5: In read mode, `dout_o` changes only after falling edges of `dclk_i`. It presents the frame in this order: end-of-conversion, overrange, sign, then the magnitude from the most significant bit down.
- R6: In read mode, before the first falling `dclk_i` edge, `dout_o` follows the live level of `eoc_i`.
- R7: The frame is captured when `rw_i` rises. Later changes of `ovr_i`, `sign_i` or `mag_i` do not alter the bits still to be shifted out.
- R8: From the 20th falling edge of a read onward, `dout_o` is low.
- R9: During reset, `time_base_o` is 0 and `load_valid_o`, `conv_start_o` and `dout_o` are low.
- R10: `load_valid_o` stays low, and no start pulse occurs, until the first accepted write commits. After that it stays high.
- R11: While `rw_i` is low, `dout_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the host clock rate |
| rst_n | input | 1 | Active-low reset |
| dclk_i | input | 1 | Host serial clock (asynchronous) |
| din_i | input | 1 | Host serial data in |
| rw_i | input | 1 | Direction: high = read frame, low = write timing word |
| eoc_i | input | 1 | End-of-conversion flag, low during auto-zero |
| ovr_i | input | 1 | Overrange flag |
| sign_i | input | 1 | Result sign |
| mag_i | input | 17 | Result magnitude |
| dout_o | output | 1 | Serial data out |
| time_base_o | output | 8 | Committed timing word for the sequencer |
| load_valid_o | output | 1 | High once a timing word has been committed |
| conv_start_o | output | 1 | One-cycle conversion start pulse |

## Verification
The assertions assume the host pins change slowly enough for every level to last several system clocks, so that each edge is detected exactly once. They also assume that a host clock edge and a direction change never land in the same detection cycle. The stimulus drives `dclk_i`, `din_i` and `rw_i` only on falling system-clock edges and holds every level for at least four cycles. It keeps `eoc_i` steady around each change of `rw_i`, and it raises `eoc_i` before lowering `rw_i` whenever it only wants to re-arm a read.

// File: rtl/cport_pkg.sv
package cport_pkg;
  localparam int unsigned STATUS_BITS = 3;  // eoc, ovr, sign

  function automatic int unsigned frame_bits(input int unsigned mag_w);
    return mag_w + STATUS_BITS;
  endfunction
endpackage

// File: rtl/cport_sync.sv
module cport_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic lvl_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= async_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], async_i};
    end
  endgenerate

  assign lvl_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cport_edge.sv
module cport_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

  p_edge_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cport_wr.sv
module cport_wr #(
  parameter int unsigned LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rw_lvl,
  input  logic              rw_rise,
  input  logic              rw_fall,
  input  logic              dclk_rise,
  input  logic              din_lvl,
  input  logic              eoc_i,
  output logic [LOAD_W-1:0] time_base_o,
  output logic              load_valid_o,
  output logic              conv_start_o
);
  logic              open_q;
  logic [LOAD_W-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q       <= 1'b0;
      shreg_q      <= '0;
      time_base_o  <= '0;
      load_valid_o <= 1'b0;
      conv_start_o <= 1'b0;
    end else begin
      conv_start_o <= 1'b0;
      if (rw_fall) begin
        // R2: only a write opened during auto-zero may commit
        open_q  <= ~eoc_i;
        shreg_q <= '0;
      end else if (rw_rise) begin
        if (open_q) begin
          time_base_o  <= shreg_q;
          load_valid_o <= 1'b1;
          conv_start_o <= 1'b1;
        end
        open_q <= 1'b0;
      end else if (!rw_lvl && open_q && dclk_rise) begin
        shreg_q <= {shreg_q[LOAD_W-2:0], din_lvl};
      end
    end
  end

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);
  p_valid_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid_o |=> load_valid_o);
  p_tb_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(time_base_o) |-> conv_start_o);
  p_start_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> load_valid_o);
endmodule

// File: rtl/cport_rd.sv
module cport_rd #(
  parameter int unsigned FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rw_lvl,
  input  logic               rw_rise,
  input  logic               rw_fall,
  input  logic               dclk_fall,
  input  logic               eoc_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               dout_o
);
  logic [FRAME_W-1:0] frame_q;
  logic               begun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      begun_q <= 1'b0;
    end else if (rw_rise) begin
      frame_q <= frame_i;  // R7: snapshot at direction change
      begun_q <= 1'b0;
    end else if (rw_fall) begin
      begun_q <= 1'b0;
    end else if (rw_lvl && dclk_fall) begin
      frame_q <= {frame_q[FRAME_W-2:0], 1'b0};  // R8: zeros fill the tail
      begun_q <= 1'b1;
    end
  end

  always_comb begin
    if (!rw_lvl)       dout_o = 1'b0;
    else if (!begun_q) dout_o = eoc_i;  // R6: live status before clocking
    else               dout_o = frame_q[FRAME_W-1];
  end

  p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_lvl && !rw_rise && !dclk_fall) |=> $stable(frame_q));
  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_lvl && !rw_rise && !rw_fall && dclk_fall) |=>
      (frame_q[FRAME_W-1:1] == $past(frame_q[FRAME_W-2:0])) && !frame_q[0]);
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port #(
  parameter int unsigned LOAD_W      = 8,
  parameter int unsigned MAG_W       = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk_i,
  input  logic              din_i,
  input  logic              rw_i,
  input  logic              eoc_i,
  input  logic              ovr_i,
  input  logic              sign_i,
  input  logic [MAG_W-1:0]  mag_i,
  output logic              dout_o,
  output logic [LOAD_W-1:0] time_base_o,
  output logic              load_valid_o,
  output logic              conv_start_o
);
  localparam int unsigned FRAME_W = cport_pkg::frame_bits(MAG_W);

  logic dclk_lvl, din_lvl, rw_lvl;
  logic dclk_rise, dclk_fall, rw_rise, rw_fall;

  cport_sync #(.STAGES(SYNC_STAGES)) u_sync_dclk (
    .clk(clk), .rst_n(rst_n), .async_i(dclk_i), .lvl_o(dclk_lvl));
  cport_sync #(.STAGES(SYNC_STAGES)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .async_i(din_i), .lvl_o(din_lvl));
  cport_sync #(.STAGES(SYNC_STAGES)) u_sync_rw (
    .clk(clk), .rst_n(rst_n), .async_i(rw_i), .lvl_o(rw_lvl));

  cport_edge u_edge_dclk (
    .clk(clk), .rst_n(rst_n), .lvl_i(dclk_lvl), .rise_o(dclk_rise), .fall_o(dclk_fall));
  cport_edge u_edge_rw (
    .clk(clk), .rst_n(rst_n), .lvl_i(rw_lvl), .rise_o(rw_rise), .fall_o(rw_fall));

  cport_wr #(.LOAD_W(LOAD_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .rw_lvl(rw_lvl), .rw_rise(rw_rise), .rw_fall(rw_fall),
    .dclk_rise(dclk_rise), .din_lvl(din_lvl), .eoc_i(eoc_i),
    .time_base_o(time_base_o), .load_valid_o(load_valid_o),
    .conv_start_o(conv_start_o));

  cport_rd #(.FRAME_W(FRAME_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rw_lvl(rw_lvl), .rw_rise(rw_rise), .rw_fall(rw_fall),
    .dclk_fall(dclk_fall), .eoc_i(eoc_i),
    .frame_i({eoc_i, ovr_i, sign_i, mag_i}),
    .dout_o(dout_o));
endmodule

// File: tb/tb_conv_serial_port.sv
module tb_conv_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0;
  logic dclk = 0, din = 0, rw = 1, eoc = 1, ovr = 0, sgn = 0;
  logic [16:0] mag = '0;
  logic dout, load_valid, conv_start;
  logic [7:0] time_base;

  int checks = 0, errors = 0, start_cnt = 0;
  bit done = 0;
  logic [7:0] exp_tb = 8'h00;

  conv_serial_port dut (
    .clk(clk), .rst_n(rst_n), .dclk_i(dclk), .din_i(din), .rw_i(rw),
    .eoc_i(eoc), .ovr_i(ovr), .sign_i(sgn), .mag_i(mag),
    .dout_o(dout), .time_base_o(time_base), .load_valid_o(load_valid),
    .conv_start_o(conv_start));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (conv_start) start_cnt <= start_cnt + 1;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // n bits of val sent first-bit-is-MSB; din flips while dclk is high
  task automatic do_write(int n, logic [15:0] val, logic eoc_lvl, bit accept);
    int s0;
    logic [15:0] m;
    eoc = eoc_lvl; rw = 0; tick(6);
    chk(dout == 1'b0, "R11", dout, 0);
    for (int i = n - 1; i >= 0; i--) begin
      din = val[i]; tick(HALF); dclk = 1; tick(2); din = ~val[i]; tick(2); dclk = 0; tick(HALF);
    end
    s0 = start_cnt;
    rw = 1; tick(8);
    m = (n >= 16) ? val : (val & ((16'h1 << n) - 16'h1));
    if (accept) exp_tb = m[7:0];
    chk(time_base == exp_tb, accept ? ((n == 8) ? "R1" : "R4") : "R2", time_base, exp_tb);
    chk(start_cnt - s0 == (accept ? 1 : 0), accept ? "R3" : "R2", start_cnt - s0, accept);
  endtask

  task automatic do_read(logic e, logic o, logic s, logic [16:0] mg, bit disturb);
    logic [19:0] fr;
    logic prev;
    eoc = 1; rw = 0; tick(6); eoc = e; tick(3);
    ovr = o; sgn = s; mag = mg;
    rw = 1; tick(8);
    fr = {e, o, s, mg};
    chk(dout == e, "R6", dout, e);
    eoc = ~e; tick(6);
    chk(dout == ~e, "R6", dout, ~e);
    eoc = e; tick(6);
    prev = dout;
    for (int k = 1; k <= 22; k++) begin
      dclk = 1; tick(HALF);
      chk(dout == prev, "R5", dout, prev);
      dclk = 0; tick(HALF);
      if (disturb && k == 5) begin ovr = ~o; sgn = ~s; mag = ~mg; end
      if (k <= 19) chk(dout == fr[19-k], disturb ? "R7" : "R5", dout, fr[19-k]);
      else         chk(dout == 1'b0, "R8", dout, 0);
      prev = dout;
    end
    chk(time_base == exp_tb, "R2", time_base, exp_tb);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R9: reset state
    chk(time_base == 8'h00, "R9", time_base, 0);
    chk(load_valid == 1'b0, "R9", load_valid, 0);
    chk(conv_start == 1'b0, "R9", conv_start, 0);
    chk(dout == 1'b0, "R9", dout, 0);
    rst_n = 1; tick(10);
    // R10: a rejected write before any load leaves conversions held off
    do_write(8, 16'h00A5, 1'b1, 0);
    chk(load_valid == 1'b0, "R10", load_valid, 0);
    chk(start_cnt == 0, "R10", start_cnt, 0);
    do_write(8, 16'h003C, 1'b0, 1);
    chk(load_valid == 1'b1, "R10", load_valid, 1);
    // R1/R3: every byte value
    for (int v = 0; v < 256; v++) do_write(8, 16'(v), 1'b0, 1);
    // R4: short and long writes
    for (int n = 1; n <= 12; n++) do_write(n, 16'hB6D9 ^ 16'(n * 37), 1'b0, 1);
    // R2: writes opened outside auto-zero
    do_write(8, 16'h005A, 1'b1, 0);
    do_write(3, 16'h0007, 1'b1, 0);
    chk(load_valid == 1'b1, "R10", load_valid, 1);
    // R5/R6/R8: frame patterns, walking one in magnitude
    do_read(1, 0, 0, 17'h00000, 0);
    do_read(0, 1, 1, 17'h1FFFF, 0);
    do_read(1, 1, 0, 17'h15555, 0);
    for (int b = 0; b < 17; b++) do_read(b[0], b[1], b[2], 17'h1 << b, 0);
    // R7: inputs change mid-frame
    do_read(1, 0, 1, 17'h0F0F3, 1);
    do_read(0, 1, 0, 17'h1A5C2, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule